// File: doc/BRIEF.md
# Watchdog Overflow Reset Sequencer

This block sits beside a watchdog counter and decides what an overflow of that counter does. A reset-enable input selects one of two responses. With the enable low, the overflow stays local: the block pulses a clear for the watchdog counter and its control/status register, and a second clear for the shared clock prescaler. With the enable high, the overflow becomes an internal manual reset request, and the request is held pending.

The processor cannot take a manual reset exception in the middle of a bus cycle. It also cannot take one while another master holds the bus or a DMA burst is running. The sequencer therefore waits for a cycle in which four things are true: a bus cycle has just ended, the CPU owns the bus, no burst is active, and the request is still pending. It then issues a one-cycle exception trigger. A pending request lives for a fixed window, 512 cycles by default. If the bus is not obtained within that window, the request is dropped silently and no exception is raised.

Top module: `wdt_overflow_reset_seq`

## Requirements
- R1: An overflow pulse seen with the reset-enable low produces a one-cycle pulse on both the watchdog clear and the prescaler clear, in the cycle after the overflow. No exception trigger ever follows from it.
- R2: An overflow pulse seen with the reset-enable high produces no clear pulse. It opens a pending manual reset request when none is pending.
- R3: The exception trigger is a one-cycle pulse. It is raised in the cycle after the first clock edge at which a request is pending, the bus-cycle-end strobe is high, the CPU-owns-bus flag is high and the burst-active flag is low.
- R4: While the CPU does not own the bus, or a burst is active, or no bus cycle has ended, a pending request is held and no trigger is raised.
- R5: A request stays pending for WINDOW_CYCLES clock edges after the edge that opened it. A grant seen at the WINDOW_CYCLES-th edge after the opening edge still triggers. A grant first seen one edge later does not, and a dropped request never triggers afterwards.
- R6: An overflow that arrives while a request is pending neither restarts nor extends the window of that request.
- R7: An overflow with the reset-enable low that arrives while a request is pending still produces both clear pulses, and the pending request is kept.
- R8: The synchronous power-on reset drives all three outputs low and discards any pending request and its window count.
- R9: Each request produces at most one trigger pulse, even when the grant conditions stay true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porRst | input | 1 | Synchronous power-on reset, active high |
| ovfPulse | input | 1 | One-cycle watchdog counter overflow pulse |
| rstEnable | input | 1 | 1: overflow requests a manual reset; 0: overflow clears locally |
| busCycleEnd | input | 1 | High in the cycle a CPU bus cycle completes |
| cpuOwnsBus | input | 1 | High while the CPU is bus master |
| burstActive | input | 1 | High while a DMA burst transfer is running |
| mrstTrigger | output | 1 | One-cycle manual reset exception trigger |
| wdtClear | output | 1 | One-cycle clear of the watchdog counter and its control/status register |
| prescClear | output | 1 | One-cycle clear of the shared clock prescaler |

## Verification
The assertions take the overflow input to be a single-cycle pulse, and they take all inputs to be synchronous to the clock and stable at every rising edge. They also take the reset-enable value that matters to be the one present in the overflow cycle. The stimulus drives every input on the falling edge and raises the overflow for exactly one cycle, with the enable set in that same cycle. Between scenarios it returns the bus inputs to a known idle state, so that no stale request carries over from one scenario into the next.

// File: rtl/wdt_rst_pkg.sv
package wdt_rst_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } seqState_t;

  // Strobes passed from the control FSM to the datapath each cycle.
  typedef struct packed {
    logic winStart;    // load the window counter with zero
    logic winAdvance;  // step the window counter by one
    logic fireTrig;    // register a trigger pulse for the next cycle
    logic fireClear;   // register both clear pulses for the next cycle
  } seqStrobe_t;

endpackage

// File: rtl/wdt_seq_ctrl.sv
module wdt_seq_ctrl
  import wdt_rst_pkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  logic       ovfPulse,
  input  logic       rstEnable,
  input  logic       busCycleEnd,
  input  logic       cpuOwnsBus,
  input  logic       burstActive,
  input  logic       winLast,
  output seqStrobe_t strobe
);

  seqState_t state;
  seqState_t stateNext;
  logic      busGrant;

  // The CPU may take the exception only at a bus-cycle boundary while it is master.
  assign busGrant = busCycleEnd && cpuOwnsBus && !burstActive;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.fireClear = ovfPulse && !rstEnable;
    case (state)
      ST_IDLE: begin
        if (ovfPulse && rstEnable) begin
          stateNext       = ST_PEND;
          strobe.winStart = 1'b1;
        end
      end
      ST_PEND: begin
        if (busGrant) begin
          strobe.fireTrig = 1'b1;
          stateNext       = ST_IDLE;
        end else if (winLast) begin
          stateNext = ST_IDLE;          // window used up: drop the request
        end else begin
          strobe.winAdvance = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (porRst) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/wdt_seq_dpath.sv
module wdt_seq_dpath
  import wdt_rst_pkg::*;
#(
  parameter int WINDOW_CYCLES = 512
) (
  input  logic       clk,
  input  logic       porRst,
  input  seqStrobe_t strobe,
  output logic       winLast,
  output logic       mrstTrigger,
  output logic       wdtClear,
  output logic       prescClear
);

  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (porRst)                 winCnt <= '0;
    else if (strobe.winStart)   winCnt <= '0;
    else if (strobe.winAdvance) winCnt <= winCnt + CNT_W'(1);
  end

  assign winLast = (winCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (porRst) begin
      mrstTrigger <= 1'b0;
      wdtClear    <= 1'b0;
      prescClear  <= 1'b0;
    end else begin
      mrstTrigger <= strobe.fireTrig;
      wdtClear    <= strobe.fireClear;
      prescClear  <= strobe.fireClear;
    end
  end

endmodule

// File: rtl/wdt_overflow_reset_seq.sv
module wdt_overflow_reset_seq
  import wdt_rst_pkg::*;
#(
  parameter int WINDOW_CYCLES = 512
) (
  input  logic clk,
  input  logic porRst,
  input  logic ovfPulse,
  input  logic rstEnable,
  input  logic busCycleEnd,
  input  logic cpuOwnsBus,
  input  logic burstActive,
  output logic mrstTrigger,
  output logic wdtClear,
  output logic prescClear
);

  seqStrobe_t strobe;
  logic       winLast;

  wdt_seq_ctrl u_ctrl (
    .clk         (clk),
    .porRst      (porRst),
    .ovfPulse    (ovfPulse),
    .rstEnable   (rstEnable),
    .busCycleEnd (busCycleEnd),
    .cpuOwnsBus  (cpuOwnsBus),
    .burstActive (burstActive),
    .winLast     (winLast),
    .strobe      (strobe)
  );

  wdt_seq_dpath #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_dpath (
    .clk         (clk),
    .porRst      (porRst),
    .strobe      (strobe),
    .winLast     (winLast),
    .mrstTrigger (mrstTrigger),
    .wdtClear    (wdtClear),
    .prescClear  (prescClear)
  );

endmodule

// File: rtl/wdt_seq_checker.sv
module wdt_seq_checker #(
  parameter int WINDOW_CYCLES = 512
) (
  input logic clk,
  input logic porRst,
  input logic ovfPulse,
  input logic rstEnable,
  input logic busCycleEnd,
  input logic cpuOwnsBus,
  input logic burstActive,
  input logic mrstTrigger,
  input logic wdtClear,
  input logic prescClear
);

  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] AGE_LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic grantSeen;
  logic armed;
  logic [CNT_W-1:0] age;

  assign grantSeen = busCycleEnd && cpuOwnsBus && !burstActive;

  // Independent tracker of whether a request may still be alive.
  always_ff @(posedge clk) begin
    if (porRst) begin
      armed <= 1'b0;
      age   <= '0;
    end else if (armed) begin
      if (grantSeen || age == AGE_LAST) armed <= 1'b0;
      else                              age   <= age + CNT_W'(1);
    end else if (ovfPulse && rstEnable) begin
      armed <= 1'b1;
      age   <= '0;
    end
  end

  assert_clear_follows_R1: assert property (@(posedge clk) disable iff (porRst)
    (ovfPulse && !rstEnable) |=> (wdtClear && prescClear));

  assert_no_clear_on_request_R2: assert property (@(posedge clk) disable iff (porRst)
    (wdtClear || prescClear) |-> $past(ovfPulse && !rstEnable));

  assert_trigger_needs_grant_R3: assert property (@(posedge clk) disable iff (porRst)
    mrstTrigger |-> $past(grantSeen));

  assert_trigger_in_window_R5: assert property (@(posedge clk) disable iff (porRst)
    mrstTrigger |-> $past(armed));

  assert_single_trigger_R9: assert property (@(posedge clk) disable iff (porRst)
    mrstTrigger |=> !mrstTrigger);

endmodule

bind wdt_overflow_reset_seq wdt_seq_checker #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_checker (
  .clk         (clk),
  .porRst      (porRst),
  .ovfPulse    (ovfPulse),
  .rstEnable   (rstEnable),
  .busCycleEnd (busCycleEnd),
  .cpuOwnsBus  (cpuOwnsBus),
  .burstActive (burstActive),
  .mrstTrigger (mrstTrigger),
  .wdtClear    (wdtClear),
  .prescClear  (prescClear)
);

// File: tb/wdt_overflow_reset_seq_bench.sv
module wdt_overflow_reset_seq_bench;

  localparam int WIN = 512;

  logic clk = 1'b0;
  logic porRst = 1'b1;
  logic ovfPulse = 1'b0;
  logic rstEnable = 1'b0;
  logic busCycleEnd = 1'b0;
  logic cpuOwnsBus = 1'b0;
  logic burstActive = 1'b0;
  logic mrstTrigger;
  logic wdtClear;
  logic prescClear;

  int testsRun = 0;
  int testsFailed = 0;
  int trigCount = 0;
  int clrCount = 0;
  int prescCount = 0;

  always #4 clk = ~clk;

  wdt_overflow_reset_seq #(.WINDOW_CYCLES(WIN)) u_wdt_overflow_reset_seq (
    .clk         (clk),
    .porRst      (porRst),
    .ovfPulse    (ovfPulse),
    .rstEnable   (rstEnable),
    .busCycleEnd (busCycleEnd),
    .cpuOwnsBus  (cpuOwnsBus),
    .burstActive (burstActive),
    .mrstTrigger (mrstTrigger),
    .wdtClear    (wdtClear),
    .prescClear  (prescClear)
  );

  // Pulse monitor: samples 2 ns after each rising edge, away from the driving edge.
  always @(posedge clk) begin
    #2;
    if (!porRst) begin
      if (mrstTrigger) trigCount++;
      if (wdtClear)    clrCount++;
      if (prescClear)  prescCount++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    @(negedge clk);
    trigCount = 0; clrCount = 0; prescCount = 0;
  endtask

  task automatic busIdleNoGrant();
    @(negedge clk);
    busCycleEnd = 1'b0; cpuOwnsBus = 1'b1; burstActive = 1'b0;
  endtask

  task automatic busGrantOn();
    @(negedge clk);
    busCycleEnd = 1'b1; cpuOwnsBus = 1'b1; burstActive = 1'b0;
  endtask

  // Overflow is high for one cycle; returns on the falling edge after the sampling edge.
  task automatic pulseOvf(logic en);
    @(negedge clk);
    ovfPulse = 1'b1; rstEnable = en;
    @(negedge clk);
    ovfPulse = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    porRst = 1'b1;
    repeat (3) @(negedge clk);
    porRst = 1'b0;
    check("R8", "trigger after reset", int'(mrstTrigger), 0);
    check("R8", "wdtClear after reset", int'(wdtClear), 0);
    check("R8", "prescClear after reset", int'(prescClear), 0);
  endtask

  task automatic t_local_clear();
    busGrantOn();
    clearCounts();
    pulseOvf(1'b0);
    check("R1", "wdtClear cycle after overflow", int'(wdtClear), 1);
    check("R1", "prescClear cycle after overflow", int'(prescClear), 1);
    @(negedge clk);
    check("R1", "wdtClear width", int'(wdtClear), 0);
    repeat (20) @(negedge clk);
    check("R1", "no trigger from local clear", trigCount, 0);
    check("R1", "prescClear pulse count", prescCount, 1);
  endtask

  task automatic t_immediate();
    busGrantOn();
    clearCounts();
    pulseOvf(1'b1);
    check("R2", "no wdtClear on request", int'(wdtClear), 0);
    @(negedge clk);
    check("R3", "trigger after first grant", int'(mrstTrigger), 1);
    @(negedge clk);
    check("R3", "trigger width", int'(mrstTrigger), 0);
    repeat (20) @(negedge clk);
    check("R9", "one trigger with grant held", trigCount, 1);
    check("R2", "no clear pulses on request", clrCount + prescCount, 0);
  endtask

  task automatic t_defer();
    @(negedge clk);
    busCycleEnd = 1'b1; cpuOwnsBus = 1'b0; burstActive = 1'b0;
    clearCounts();
    pulseOvf(1'b1);
    repeat (50) @(negedge clk);
    check("R4", "held while bus released", trigCount, 0);
    cpuOwnsBus = 1'b1; burstActive = 1'b1;
    repeat (30) @(negedge clk);
    check("R4", "held during burst", trigCount, 0);
    burstActive = 1'b0; busCycleEnd = 1'b0;
    repeat (30) @(negedge clk);
    check("R4", "held inside bus cycle", trigCount, 0);
    busCycleEnd = 1'b1;
    @(negedge clk);
    busCycleEnd = 1'b0;
    check("R3", "trigger after deferred grant", int'(mrstTrigger), 1);
    repeat (10) @(negedge clk);
    check("R4", "single deferred trigger", trigCount, 1);
  endtask

  task automatic t_window_edge();
    busIdleNoGrant();
    clearCounts();
    pulseOvf(1'b1);
    repeat (WIN - 1) @(negedge clk);
    busCycleEnd = 1'b1;
    repeat (5) @(negedge clk);
    check("R5", "grant at last window edge", trigCount, 1);
    busCycleEnd = 1'b0;
  endtask

  task automatic t_window_miss();
    busIdleNoGrant();
    clearCounts();
    pulseOvf(1'b1);
    repeat (WIN) @(negedge clk);
    busCycleEnd = 1'b1;
    repeat (25) @(negedge clk);
    check("R5", "grant one edge past window", trigCount, 0);
    busCycleEnd = 1'b0;
  endtask

  task automatic t_no_restart();
    busIdleNoGrant();
    clearCounts();
    pulseOvf(1'b1);
    repeat (298) @(negedge clk);
    pulseOvf(1'b1);
    repeat (212) @(negedge clk);
    busCycleEnd = 1'b1;
    repeat (10) @(negedge clk);
    check("R6", "second overflow does not extend window", trigCount, 0);
    check("R6", "no clear from second request overflow", clrCount, 0);
    busCycleEnd = 1'b0;
  endtask

  task automatic t_local_while_pending();
    busIdleNoGrant();
    clearCounts();
    pulseOvf(1'b1);
    repeat (10) @(negedge clk);
    pulseOvf(1'b0);
    check("R7", "wdtClear while pending", int'(wdtClear), 1);
    check("R7", "prescClear while pending", int'(prescClear), 1);
    repeat (5) @(negedge clk);
    busCycleEnd = 1'b1;
    repeat (5) @(negedge clk);
    check("R7", "request kept after local clear", trigCount, 1);
    busCycleEnd = 1'b0;
  endtask

  task automatic t_por_cancel();
    busIdleNoGrant();
    clearCounts();
    pulseOvf(1'b1);
    repeat (10) @(negedge clk);
    porRst = 1'b1;
    repeat (2) @(negedge clk);
    porRst = 1'b0;
    busCycleEnd = 1'b1;
    repeat (20) @(negedge clk);
    check("R8", "reset discards pending request", trigCount, 0);
    busCycleEnd = 1'b0;
    // Fresh request after reset still gets its full window from zero.
    clearCounts();
    pulseOvf(1'b1);
    repeat (WIN - 1) @(negedge clk);
    busCycleEnd = 1'b1;
    repeat (5) @(negedge clk);
    check("R8", "window restarts cleanly after reset", trigCount, 1);
    busCycleEnd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    t_reset();
    t_local_clear();
    t_immediate();
    t_defer();
    t_window_edge();
    t_window_miss();
    t_no_restart();
    t_local_while_pending();
    t_por_cancel();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule